// File: doc/BRIEF.md
# Interrupt Router Register Front End

This block is the software-visible register layer of a 24-input interrupt router. A processor reaches it through two 32-bit locations on a simple single-cycle register bus: an index register and a data window. Writing the index register chooses which internal register the window stands for. Reading or writing the window then reaches that register. Behind the window sit three registers: a 4-bit router identifier, a read-only version word, and one 64-bit routing entry per input pin. Each routing entry is reached as two 32-bit halves.

Table writes have side effects on interrupt state. A write to the low half of an entry clears the entry's in-service flag. If the write flips the entry's mask bit, the block emits a one-cycle notice that carries the pin number and the new mask value. If the pin already has a pending request when its entry is written, the block emits a one-cycle re-service request for that pin. The pending vector is set and cleared through dedicated per-pin inputs. Interrupt delivery and trigger handling belong to neighbouring logic.

Top module: `irq_route_regs`

## Requirements
- R1: After reset, every entry reads 0x0001_0000 in its low half and 0 in its high half (mask bit 16 set, all else clear). The index register reads 0, the identifier reads 0, and the pending vector is empty.
- R2: Only address bits 7:0 are decoded. Offset 0x00 is the index register, which holds a full 32-bit value. Offset 0x10 is the data window. Reads of any other offset return 0, and writes to any other offset change nothing.
- R3: A write is taken only when its size is 4 or 8 bytes. Only write data bits 31:0 are used.
- R4: Index 0x01 reads ((pins − 1) << 16) | VER_CODE, which is 0x0017_0011 by default. Writes to it change nothing.
- R5: Index 0x00 holds the identifier in bits 27:24. A write there stores data bits 27:24, and all other read bits are 0. Index 0x02 reads the same value, and writes to index 0x02 are ignored.
- R6: An index of 0x10 or above selects entry (index − 0x10) >> 1. An even index reaches entry bits 31:0, and an odd index reaches entry bits 63:32.
- R7: Entries at or beyond the pin count read 0, and writes to them are dropped. Indexes 0x03 to 0x0F also read 0.
- R8: A low-half write always leaves remote-IRR (entry bit 14) at 0. A high-half write leaves the low half unchanged.
- R9: In the cycle after a low-half write that changes mask bit 16, mask_evt is 1 and carries the pin and the new mask. No pulse follows a write that leaves the mask unchanged.
- R10: The pending bit for a pin is set by pend_set and cleared by pend_clr; the clear wins when both are asserted. In the cycle after any table write to a pin whose pending bit is set, svc_req is 1 and svc_pin names that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Byte address; only bits 7:0 are decoded |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 64 | Write data; bits 31:0 are used |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pend_set | input | NUM_PINS (24) | Per-pin pending set |
| pend_clr | input | NUM_PINS (24) | Per-pin pending clear, wins over set |
| mask_evt | output | 1 | One-cycle mask-change notice |
| mask_evt_pin | output | PIN_W (5) | Pin whose mask changed |
| mask_evt_val | output | 1 | New mask value |
| svc_req | output | 1 | One-cycle re-service request |
| svc_pin | output | PIN_W (5) | Pin to be re-serviced |

## Verification
Some properties are checked on every cycle. A mask notice must follow a low-half write and must agree with the stored mask. A service request must follow a table write to a pending pin. Remote-IRR is clear after every low-half write, and a high-half write leaves the low half untouched. The index register and the identifier change only on their own writes. The bench scenarios are needed for the rest: address and index decoding, the version and identifier words, out-of-range and reserved indexes, rejected access sizes, reset contents, and clear-over-set ordering on the pending vector.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam logic [7:0]  OFS_INDEX   = 8'h00;
    localparam logic [7:0]  OFS_WINDOW  = 8'h10;
    localparam logic [31:0] IDX_IDENT   = 32'h00;
    localparam logic [31:0] IDX_VERSION = 32'h01;
    localparam logic [31:0] IDX_ARBIT   = 32'h02;
    localparam logic [31:0] IDX_TABLE   = 32'h10;

    // one routing entry, 64 bits, laid out as the decode logic of neighbours expects
    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd_hi;
        logic        mask;
        logic        level;
        logic        rirr;
        logic        polarity;
        logic        rsvd_lo;
        logic        dest_logical;
        logic [2:0]  dlv_mode;
        logic [7:0]  vector;
    } route_ent_t;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_IDENT,
        TGT_VERSION,
        TGT_ARBIT,
        TGT_ENTRY
    } tgt_e;

    typedef struct packed {
        tgt_e        tgt;
        logic        hi;
        logic [30:0] idx;
    } sel_dec_t;

    function automatic logic size_ok(input logic [3:0] sz);
        return (sz == 4'd4) || (sz == 4'd8);
    endfunction

    function automatic sel_dec_t decode_index(input logic [31:0] sel, input int unsigned npins);
        sel_dec_t    d;
        logic [31:0] off;
        off   = sel - IDX_TABLE;
        d.idx = off[31:1];
        d.hi  = sel[0];
        if (sel == IDX_IDENT)          d.tgt = TGT_IDENT;
        else if (sel == IDX_VERSION)   d.tgt = TGT_VERSION;
        else if (sel == IDX_ARBIT)     d.tgt = TGT_ARBIT;
        else if (sel < IDX_TABLE)      d.tgt = TGT_NONE;
        else if (d.idx < 31'(npins))   d.tgt = TGT_ENTRY;
        else                           d.tgt = TGT_NONE;
        return d;
    endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic [7:0]       ofs,
    input  logic [31:0]      sel_q,
    output logic             hit_index,
    output logic             hit_window,
    output tgt_e             tgt,
    output logic             ent_hi,
    output logic [PIN_W-1:0] ent_idx
);
    sel_dec_t dec;

    always_comb begin
        hit_index  = (ofs == OFS_INDEX);
        hit_window = (ofs == OFS_WINDOW);
        dec        = decode_index(sel_q, NUM_PINS);
        tgt        = dec.tgt;
        ent_hi     = dec.hi;
        ent_idx    = dec.idx[PIN_W-1:0];
    end

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_hi,
    input  logic [PIN_W-1:0]    wr_idx,
    input  logic [31:0]         wr_word,
    input  logic [NUM_PINS-1:0] pend_set,
    input  logic [NUM_PINS-1:0] pend_clr,
    input  logic [PIN_W-1:0]    rd_idx,
    input  logic                rd_hi,
    output logic [31:0]         rd_word,
    output logic                mask_evt,
    output logic [PIN_W-1:0]    mask_evt_pin,
    output logic                mask_evt_val,
    output logic                svc_req,
    output logic [PIN_W-1:0]    svc_pin
);
    localparam route_ent_t RESET_ENT = '{mask: 1'b1, default: '0};

    route_ent_t          ent_q [NUM_PINS];
    logic [NUM_PINS-1:0] pend_q;
    logic [NUM_PINS-1:0] mask_vec;
    logic                old_mask;
    logic                new_mask;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_mask
        assign mask_vec[p] = ent_q[p].mask;
    end

    assign old_mask = mask_vec[wr_idx];
    assign new_mask = wr_word[16];

    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PINS; p++) begin
            if (rst) begin
                ent_q[p] <= RESET_ENT;
            end else if (wr_en && (wr_idx == PIN_W'(p))) begin
                if (wr_hi) begin
                    ent_q[p][63:32] <= wr_word;
                end else begin
                    ent_q[p][31:0] <= wr_word;
                    ent_q[p].rirr  <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q       <= '0;
            mask_evt     <= 1'b0;
            mask_evt_pin <= '0;
            mask_evt_val <= 1'b0;
            svc_req      <= 1'b0;
            svc_pin      <= '0;
        end else begin
            pend_q   <= (pend_q | pend_set) & ~pend_clr;
            mask_evt <= wr_en && !wr_hi && (new_mask != old_mask);
            if (wr_en && !wr_hi && (new_mask != old_mask)) begin
                mask_evt_pin <= wr_idx;
                mask_evt_val <= new_mask;
            end
            svc_req <= wr_en && pend_q[wr_idx];
            if (wr_en) svc_pin <= wr_idx;
        end
    end

    assign rd_word = rd_hi ? ent_q[rd_idx][63:32] : ent_q[rd_idx][31:0];

    // R9
    evt_needs_low_write_chk: assert property (@(posedge clk) disable iff (rst)
        mask_evt |-> $past(wr_en && !wr_hi));
    // R9
    evt_value_match_chk: assert property (@(posedge clk) disable iff (rst)
        mask_evt |-> (mask_vec[mask_evt_pin] == mask_evt_val));
    // R8
    rirr_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && !wr_hi) |-> !ent_q[$past(wr_idx)].rirr);
    // R8
    hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && wr_hi) |-> (ent_q[$past(wr_idx)][31:0] == $past(ent_q[wr_idx][31:0])));
    // R10
    svc_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        svc_req |-> $past(wr_en && pend_q[wr_idx]));

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter int         ADDR_W   = 12,
    parameter logic [7:0] VER_CODE = 8'h11,
    localparam int        PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [3:0]          bus_size,
    input  logic [63:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pend_set,
    input  logic [NUM_PINS-1:0] pend_clr,
    output logic                mask_evt,
    output logic [PIN_W-1:0]    mask_evt_pin,
    output logic                mask_evt_val,
    output logic                svc_req,
    output logic [PIN_W-1:0]    svc_pin
);
    localparam logic [31:0] VERSION_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VER_CODE};

    logic [31:0]      sel_q;
    logic [3:0]       ident_q;
    logic             hit_index;
    logic             hit_window;
    tgt_e             tgt;
    logic             ent_hi;
    logic [PIN_W-1:0] ent_idx;
    logic             wr_ok;
    logic             sel_we;
    logic             ident_we;
    logic             tbl_we;
    logic [31:0]      tbl_word;

    irq_route_decode #(.NUM_PINS(NUM_PINS)) u_dec (
        .ofs        (bus_addr[7:0]),
        .sel_q      (sel_q),
        .hit_index  (hit_index),
        .hit_window (hit_window),
        .tgt        (tgt),
        .ent_hi     (ent_hi),
        .ent_idx    (ent_idx)
    );

    assign wr_ok    = bus_wr && size_ok(bus_size);
    assign sel_we   = wr_ok && hit_index;
    assign ident_we = wr_ok && hit_window && (tgt == TGT_IDENT);
    assign tbl_we   = wr_ok && hit_window && (tgt == TGT_ENTRY);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            ident_q <= '0;
        end else begin
            if (sel_we)   sel_q   <= bus_wdata[31:0];
            if (ident_we) ident_q <= bus_wdata[27:24];
        end
    end

    irq_route_table #(.NUM_PINS(NUM_PINS)) u_tbl (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (tbl_we),
        .wr_hi        (ent_hi),
        .wr_idx       (ent_idx),
        .wr_word      (bus_wdata[31:0]),
        .pend_set     (pend_set),
        .pend_clr     (pend_clr),
        .rd_idx       (ent_idx),
        .rd_hi        (ent_hi),
        .rd_word      (tbl_word),
        .mask_evt     (mask_evt),
        .mask_evt_pin (mask_evt_pin),
        .mask_evt_val (mask_evt_val),
        .svc_req      (svc_req),
        .svc_pin      (svc_pin)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_index) begin
            bus_rdata = sel_q;
        end else if (hit_window) begin
            unique case (tgt)
                TGT_IDENT, TGT_ARBIT: bus_rdata = {4'h0, ident_q, 24'h0};
                TGT_VERSION:          bus_rdata = VERSION_WORD;
                TGT_ENTRY:            bus_rdata = tbl_word;
                default:              bus_rdata = '0;
            endcase
        end
    end

    // R2
    index_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(sel_we) |-> $stable(sel_q));
    // R5
    ident_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(ident_we) |-> $stable(ident_q));

endmodule

// File: tb/sim_irq_route_regs.sv
module sim_irq_route_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_PINS   = 24;
    localparam int PIN_W      = 5;
    localparam int NVEC       = 9;

    // {index, window write data, expected window read}
    localparam logic [95:0] VEC [NVEC] = '{
        {32'h10, 32'h0001_4025, 32'h0001_0025},
        {32'h11, 32'hAB00_0000, 32'hAB00_0000},
        {32'h3F, 32'h1234_5678, 32'h1234_5678},
        {32'h3E, 32'h0000_80FF, 32'h0000_80FF},
        {32'h40, 32'hFFFF_FFFF, 32'h0000_0000},
        {32'h01, 32'h0000_0000, 32'h0017_0011},
        {32'h00, 32'hF5FF_FFFF, 32'h0500_0000},
        {32'h02, 32'h0A00_0000, 32'h0500_0000},
        {32'h05, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [11:0]         bus_addr = '0;
    logic                bus_wr = 1'b0;
    logic [3:0]          bus_size = 4'd4;
    logic [63:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [NUM_PINS-1:0] pend_set = '0;
    logic [NUM_PINS-1:0] pend_clr = '0;
    logic                mask_evt;
    logic [PIN_W-1:0]    mask_evt_pin;
    logic                mask_evt_val;
    logic                svc_req;
    logic [PIN_W-1:0]    svc_pin;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [31:0] got;

    irq_route_regs u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [3:0] sz, input logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 v = bus_rdata;
    endtask

    task automatic sel_rd(input logic [31:0] idx, output logic [31:0] v);
        wr(12'h000, 4'd4, {32'h0, idx});
        rd(12'h010, v);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset values
        rd(12'h000, got);  chk("R1 index", got, 32'h0);
        rd(12'h010, got);  chk("R1 ident", got, 32'h0);
        sel_rd(32'h10, got); chk("R1 pin0 lo", got, 32'h0001_0000);
        sel_rd(32'h11, got); chk("R1 pin0 hi", got, 32'h0);
        sel_rd(32'h3E, got); chk("R1 pin23 lo", got, 32'h0001_0000);
        wr(12'h010, 4'd4, 64'h0001_0000);
        chk("R1 no pending", {31'h0, svc_req}, 32'h0);
        chk("R1 no mask change", {31'h0, mask_evt}, 32'h0);

        // R4 R5 R6 R7 R8 vector walk
        for (int i = 0; i < NVEC; i++) begin
            wr(12'h000, 4'd4, {32'h0, VEC[i][95:64]});
            wr(12'h010, 4'd4, {32'h0, VEC[i][63:32]});
            rd(12'h010, got);
            chk($sformatf("R6/R4/R5/R7/R8 vec%0d", i), got, VEC[i][31:0]);
        end

        // R2 decode
        wr(12'h000, 4'd4, 64'hDEAD_0010);
        rd(12'h000, got);  chk("R2 index full width", got, 32'hDEAD_0010);
        rd(12'h010, got);  chk("R7 huge index reads 0", got, 32'h0);
        wr(12'h020, 4'd4, 64'h0000_0001);
        rd(12'h000, got);  chk("R2 other offset write ignored", got, 32'hDEAD_0010);
        rd(12'h020, got);  chk("R2 other offset reads 0", got, 32'h0);
        wr(12'h100, 4'd4, 64'h0000_0001);
        rd(12'h110, got);  chk("R2 high addr bits ignored", got, 32'h0017_0011);

        // R3 access size and data width
        wr(12'h000, 4'd2, 64'h0000_0014);
        rd(12'h000, got);  chk("R3 size 2 ignored", got, 32'h0000_0001);
        wr(12'h000, 4'd8, 64'hFFFF_FFFF_0000_0012);
        rd(12'h000, got);  chk("R3 size 8 low word", got, 32'h0000_0012);
        wr(12'h010, 4'd1, 64'h0000_0000);
        rd(12'h010, got);  chk("R3 size 1 window ignored", got, 32'h0001_0000);

        // R9 mask change notice, pin 1 low half at index 0x12
        wr(12'h010, 4'd4, 64'h0000_0000);
        chk("R9 evt", {31'h0, mask_evt}, 32'h1);
        chk("R9 pin", {27'h0, mask_evt_pin}, 32'd1);
        chk("R9 val", {31'h0, mask_evt_val}, 32'h0);
        wr(12'h010, 4'd4, 64'h0000_0042);
        chk("R9 unchanged no evt", {31'h0, mask_evt}, 32'h0);
        wr(12'h010, 4'd4, 64'h0001_0042);
        chk("R9 evt unmask->mask", {31'h0, mask_evt}, 32'h1);
        chk("R9 val 1", {31'h0, mask_evt_val}, 32'h1);
        wr(12'h000, 4'd4, 64'h13);
        wr(12'h010, 4'd4, 64'hFFFF_FFFF);
        chk("R9 hi write no evt", {31'h0, mask_evt}, 32'h0);

        // R8 high write keeps low, low write clears remote-IRR
        sel_rd(32'h12, got); chk("R8 low kept", got, 32'h0001_0042);
        wr(12'h010, 4'd4, 64'h0000_40AA);
        rd(12'h010, got);  chk("R8 rirr cleared", got, 32'h0000_00AA);

        // R10 re-service on pending pin
        @(negedge clk) pend_set = 24'h20;
        @(negedge clk) pend_set = '0;
        wr(12'h000, 4'd4, 64'h1B);
        wr(12'h010, 4'd4, 64'h0000_0000);
        chk("R10 svc", {31'h0, svc_req}, 32'h1);
        chk("R10 svc pin", {27'h0, svc_pin}, 32'd5);
        wr(12'h000, 4'd4, 64'h1D);
        wr(12'h010, 4'd4, 64'h0000_0000);
        chk("R10 no svc idle pin", {31'h0, svc_req}, 32'h0);
        @(negedge clk) begin pend_set = 24'h20; pend_clr = 24'h20; end
        @(negedge clk) begin pend_set = '0; pend_clr = '0; end
        wr(12'h000, 4'd4, 64'h1B);
        wr(12'h010, 4'd4, 64'h0000_0000);
        chk("R10 clear wins", {31'h0, svc_req}, 32'h0);

        finish_run();
    end

endmodule